// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small register with a parameterised width. On each rising clock edge a two-bit mode input selects one of four actions: a parallel load of a new word, a shift one place toward bit 0, a shift one place toward the top bit, or no change. Each end of the register has its own serial input. A bit shifted toward bit 0 enters at the top bit. A bit shifted toward the top enters at bit 0.

Every flip-flop has a four-way selector in front of it. All bits take their new values on the same edge, so a shift never passes through a partly moved state. An active-low clear acts asynchronously and sets every bit to zero. The block can gather a serial stream into a parallel word. It can also load a word and send it out one bit at a time from either end.

Top module: `ushr_core`

## Requirements
- R1: While `rst_n` is low, `q_o` is all zeros. The clear takes effect at once, without waiting for a clock edge, and overrides every mode.
- R2: With `mode_i` = 2'b11, the next rising edge copies `par_i` into `q_o`.
- R3: With `mode_i` = 2'b10, the next rising edge moves every bit one position toward bit 0. Bit W-1 takes `fill_hi_i` and the old bit 0 is dropped.
- R4: With `mode_i` = 2'b01, the next rising edge moves every bit one position toward bit W-1. Bit 0 takes `fill_lo_i` and the old bit W-1 is dropped.
- R5: With `mode_i` = 2'b00, `q_o` keeps its value across the edge, whatever `par_i`, `fill_hi_i` and `fill_lo_i` are.
- R6: After W edges in mode 2'b01 starting from any state, `q_o` holds the bits presented on `fill_lo_i`. The first bit presented ends in bit W-1 and the last in bit 0.
- R7: After a load in mode 2'b11 followed by edges in mode 2'b10, `q_o[0]` presents the loaded word one bit per cycle, least significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | Action select: 11 load, 10 shift toward bit 0, 01 shift toward top bit, 00 hold |
| fill_hi_i | input | 1 | Serial bit that enters bit W-1 on a shift toward bit 0 |
| fill_lo_i | input | 1 | Serial bit that enters bit 0 on a shift toward the top bit |
| par_i | input | W | Parallel word taken in load mode |
| q_o | output | W | Register contents |

## Verification
On every cycle, the assertions check that `q_o` after each edge matches the mode seen before it. This covers load, both shift directions and hold. They also check that the output reads zero whenever the clear is low. Some behaviours only the bench's scenarios can show. One is the clear acting between clock edges. The others are the multi-cycle results: a whole word assembled from a serial stream, and a loaded word drained bit by bit in the right order. The bench also shows that the unused serial and parallel inputs have no effect while the register holds.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'b00,
        MODE_TO_MSB  = 2'b01,
        MODE_TO_LSB  = 2'b10,
        MODE_LOAD    = 2'b11
    } ushr_mode_e;

    typedef struct packed {
        logic load;
        logic to_lsb;
        logic to_msb;
        logic hold;
    } ushr_sel_t;

endpackage

// File: rtl/ushr_mode_dec.sv
module ushr_mode_dec
    import ushr_pkg::*;
(
    input  logic [1:0] mode_i,
    output ushr_sel_t  sel_o
);

    always_comb begin
        sel_o = '0;
        unique case (ushr_mode_e'(mode_i))
            MODE_LOAD:   sel_o.load   = 1'b1;
            MODE_TO_LSB: sel_o.to_lsb = 1'b1;
            MODE_TO_MSB: sel_o.to_msb = 1'b1;
            default:     sel_o.hold   = 1'b1;
        endcase
    end

endmodule

// File: rtl/ushr_bit_cell.sv
module ushr_bit_cell
    import ushr_pkg::*;
(
    input  ushr_sel_t sel_i,
    input  logic      own_i,
    input  logic      from_up_i,
    input  logic      from_dn_i,
    input  logic      par_i,
    output logic      nxt_o
);

    always_comb begin
        nxt_o = own_i;
        if (sel_i.load)
            nxt_o = par_i;
        else if (sel_i.to_lsb)
            nxt_o = from_up_i;
        else if (sel_i.to_msb)
            nxt_o = from_dn_i;
    end

endmodule

// File: rtl/ushr_core.sv
module ushr_core
    import ushr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         fill_hi_i,
    input  logic         fill_lo_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o
);

    localparam int TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] bits;
    } reg_st_t;

    reg_st_t      st_d, st_q;
    ushr_sel_t    sel;
    logic [W-1:0] cell_nxt;

    ushr_mode_dec u_dec (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic up_src, dn_src;
        if (i == TOP) begin : g_top
            assign up_src = fill_hi_i;
        end else begin : g_mid_up
            assign up_src = st_q.bits[i+1];
        end
        if (i == 0) begin : g_bot
            assign dn_src = fill_lo_i;
        end else begin : g_mid_dn
            assign dn_src = st_q.bits[i-1];
        end
        ushr_bit_cell u_cell (
            .sel_i     (sel),
            .own_i     (st_q.bits[i]),
            .from_up_i (up_src),
            .from_dn_i (dn_src),
            .par_i     (par_i[i]),
            .nxt_o     (cell_nxt[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = cell_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign q_o = st_q.bits;

    AST_CLEAR_ZERO: assert property (@(posedge clk) !rst_n |-> (q_o == '0)); // R1

    AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> (q_o == $past(par_i))); // R2

    AST_SHIFT_TO_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |=> (q_o == {$past(fill_hi_i), $past(q_o[W-1:1])})); // R3

    AST_SHIFT_TO_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |=> (q_o == {$past(q_o[W-2:0]), $past(fill_lo_i)})); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |=> $stable(q_o)); // R5

endmodule

// File: tb/sim_ushr_core.sv
`timescale 1ns/1ps
module sim_ushr_core;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_i = 2'b00;
    logic         fill_hi_i = 1'b0;
    logic         fill_lo_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic [W-1:0] q_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ushr_core #(.W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .fill_hi_i (fill_hi_i),
        .fill_lo_i (fill_lo_i),
        .par_i     (par_i),
        .q_o       (q_o)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [W-1:0] p, input logic hi, input logic lo);
        @(negedge clk);
        mode_i = m; par_i = p; fill_hi_i = hi; fill_lo_i = lo;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        check("R1 reset state", q_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_load;
        step(2'b11, 4'b1011, 1'b0, 1'b1);
        check("R2 load 1011", q_o, 4'b1011);
        step(2'b11, 4'b0110, 1'b1, 1'b0);
        check("R2 load 0110", q_o, 4'b0110);
    endtask

    task automatic t_shift_lsb;
        step(2'b11, 4'b1001, 1'b0, 1'b0);
        step(2'b10, 4'b1111, 1'b1, 1'b0);
        check("R3 shift toward bit0 fill 1", q_o, 4'b1100);
        step(2'b10, 4'b0000, 1'b0, 1'b1);
        check("R3 shift toward bit0 fill 0", q_o, 4'b0110);
    endtask

    task automatic t_shift_msb;
        step(2'b11, 4'b1001, 1'b0, 1'b0);
        step(2'b01, 4'b1111, 1'b0, 1'b1);
        check("R4 shift toward top fill 1", q_o, 4'b0011);
        step(2'b01, 4'b0000, 1'b1, 1'b0);
        check("R4 shift toward top fill 0", q_o, 4'b0110);
    endtask

    task automatic t_hold;
        step(2'b11, 4'b1010, 1'b0, 1'b0);
        step(2'b00, 4'b0101, 1'b1, 1'b1);
        check("R5 hold ignores inputs", q_o, 4'b1010);
        step(2'b00, 4'b1111, 1'b0, 1'b0);
        check("R5 hold second cycle", q_o, 4'b1010);
    endtask

    task automatic t_s2p;
        logic [W-1:0] stream;
        stream = 4'b1101;
        step(2'b11, 4'b0110, 1'b0, 1'b0);
        for (int k = W - 1; k >= 0; k--)
            step(2'b01, 4'b0000, 1'b0, stream[k]);
        check("R6 serial to parallel", q_o, stream);
    endtask

    task automatic t_p2s;
        logic [W-1:0] word, seen;
        word = 4'b0111;
        seen = '0;
        step(2'b11, word, 1'b0, 1'b0);
        seen[0] = q_o[0];
        for (int k = 1; k < W; k++) begin
            step(2'b10, 4'b0000, 1'b0, 1'b0);
            seen[k] = q_o[0];
        end
        check("R7 parallel to serial order", seen, word);
        check("R7 drained with fill 0", q_o, 4'b0000);
    endtask

    task automatic t_async_clear;
        step(2'b11, 4'b1111, 1'b0, 1'b0);
        @(negedge clk);
        mode_i = 2'b11; par_i = 4'b1111;
        #0.5;
        rst_n = 1'b0;
        #0.5;
        check("R1 async clear between edges", q_o, '0);
        @(posedge clk);
        #1;
        check("R1 clear overrides load", q_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        mode_i = 2'b00;
    endtask

    initial begin
        #2;
        t_reset();
        t_load();
        t_shift_lsb();
        t_shift_msb();
        t_hold();
        t_s2p();
        t_p2s();
        t_async_clear();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule